// File: doc/BRIEF.md
# Multichannel Pulse-Width Modulator with Shared Prescaler

This block drives several pulse-width modulated outputs from one common time base. One 8-bit prescaler divides the input clock into a slower local tick. One 8-bit counter then counts local ticks, and every period is exactly 256 local ticks long. Each channel compares that shared count against its own duty value, so every channel runs at the same period and all channels start their periods together. Software changes the period only through the prescaler. Software changes each pulse width through that channel's duty value.

Configuration goes through a small word-addressed register port. Each channel has a duty register. A control register holds the prescaler, split into two nibbles that are not next to each other, together with a single run enable. A third register stores one interrupt-enable bit, and that bit is also driven out on a pin. The block takes a duty or prescaler change only when the counter wraps, so no period is ever cut short or stretched.

Top module: `pwmx_top`

## Requirements
- R1: Channel n's duty register is at byte offset 4*n, with the duty in bits [7:0]. It reads back with all upper bits zero. A write to an offset with bits [1:0] not zero, or to an offset that matches no register, changes nothing. Such an offset reads zero.
- R2: The control register is at offset 0x50. The prescaler low nibble is in bits [3:0], the prescaler high nibble is in bits [14:11], and the run enable is bit 9. All other bits read as zero, and writes to them are ignored.
- R3: The interrupt-enable register is at offset 0x54. Its bit 0 is stored, reads back, and drives `irq_en`. All other bits read zero.
- R4: One local tick lasts (prescale + 1) input clocks. One period lasts 256 local ticks, so the period is 256*(prescale + 1) input clocks.
- R5: An output stays high for (duty + 1) local ticks at the start of each period and stays low for the rest of the period. A duty of 0 gives one tick high. A duty of 255 keeps the output high all the time.
- R6: All channels share the period, and all of them go high together at the first tick of each period.
- R7: While the run enable is clear, all outputs are low and the counters are held at zero. Setting the enable starts a fresh period one input clock after the write edge, and the first sampled cycle is count 0.
- R8: A duty or prescaler write made while the block is running changes nothing until the counter wraps from 255 to 0. The new values apply from the next period on.
- R9: After reset, every register reads zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Byte offset for the read and the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_en | output | 1 | Stored interrupt-enable bit |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
Embedded assertions check three things on every cycle. They check that the counters stay cleared while the block is stopped, that the count advances only on a local tick, and that the active duty copy moves only at a wrap. They also check the all-high start of each period, the low outputs while stopped, and the zeroed reserved read bits. Other behaviour shows only in the bench's scenarios, which compare every output on every cycle against an arithmetic model. These scenarios cover the exact pulse widths for several prescaler and duty mixes (including the split high nibble), the deferral of a mid-period change to the next wrap, and the restart after a stop.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;
  // byte offsets of the shared registers
  localparam logic [7:0] CTRL_OFS = 8'h50;
  localparam logic [7:0] IEN_OFS  = 8'h54;

  // control register field positions
  localparam int PS_LO_LSB = 0;
  localparam int PS_HI_LSB = 11;
  localparam int RUN_BIT   = 9;
  localparam int PS_W      = 8;

  // mask of the control bits that hold state
  localparam logic [31:0] CTRL_MASK = 32'h0000_7A0F;

  // pack prescaler and run flag into a control word
  function automatic logic [31:0] ctrl_pack(input logic [PS_W-1:0] ps, input logic run);
    logic [31:0] w;
    w = '0;
    w[PS_LO_LSB +: 4] = ps[3:0];
    w[PS_HI_LSB +: 4] = ps[7:4];
    w[RUN_BIT]        = run;
    return w;
  endfunction

  // recover the prescaler from a control word
  function automatic logic [PS_W-1:0] ctrl_ps(input logic [31:0] w);
    return {w[PS_HI_LSB +: 4], w[PS_LO_LSB +: 4]};
  endfunction

  // channel level for a given count and duty: high while count <= duty
  function automatic logic level_at(input int unsigned cnt, input int unsigned duty);
    return cnt <= duty;
  endfunction
endpackage

// File: rtl/pwmx_regs.sv
module pwmx_regs
  import pwmx_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DUTY_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic [NUM_CH*DUTY_W-1:0] duty_flat,
  output logic [PS_W-1:0]          ps_cfg,
  output logic                     run_cfg,
  output logic                     ien_q
);
  localparam int WORD_W   = ADDR_W - 2;
  localparam int CTRL_IDX = int'(CTRL_OFS) / 4;
  localparam int IEN_IDX  = int'(IEN_OFS) / 4;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              wr_ok;
  logic [DUTY_W-1:0] duty_q [NUM_CH];
  logic              unused_wdata;

  assign word         = bus_addr[ADDR_W-1:2];
  assign aligned      = (bus_addr[1:0] == 2'b00);
  assign wr_ok        = bus_wr && aligned;
  assign unused_wdata = ^bus_wdata;

  // per-channel duty storage
  for (genvar g = 0; g < NUM_CH; g++) begin : g_duty
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) duty_q[g] <= '0;
      else if (wr_ok && int'(word) == g) duty_q[g] <= bus_wdata[DUTY_W-1:0];
    end
    assign duty_flat[g*DUTY_W +: DUTY_W] = duty_q[g];
  end

  // control and interrupt-enable storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_cfg  <= '0;
      run_cfg <= 1'b0;
      ien_q   <= 1'b0;
    end else if (wr_ok) begin
      if (int'(word) == CTRL_IDX) begin
        ps_cfg  <= ctrl_ps(bus_wdata);
        run_cfg <= bus_wdata[RUN_BIT];
      end
      if (int'(word) == IEN_IDX) ien_q <= bus_wdata[0];
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (int'(word) == CTRL_IDX) bus_rdata = ctrl_pack(ps_cfg, run_cfg);
      else if (int'(word) == IEN_IDX) bus_rdata[0] = ien_q;
      else begin
        for (int ch = 0; ch < NUM_CH; ch++) begin
          if (int'(word) == ch) bus_rdata[DUTY_W-1:0] = duty_q[ch];
        end
      end
    end
  end

  assert_ctrl_resv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(CTRL_OFS)) |-> ((bus_rdata & ~CTRL_MASK) == '0));

  assert_ien_resv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(IEN_OFS)) |-> (bus_rdata[31:1] == '0 && bus_rdata[0] == ien_q));
endmodule

// File: rtl/pwmx_timebase.sv
module pwmx_timebase
  import pwmx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_cfg,
  input  logic [PS_W-1:0]  ps_cfg,
  output logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             load
);
  logic [PS_W-1:0] presc;
  logic [PS_W-1:0] ps_act;
  logic            tick;

  assign tick = run && (presc == ps_act);
  assign wrap = tick && (cnt == '1);
  assign load = !run || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      presc  <= '0;
      cnt    <= '0;
      ps_act <= '0;
    end else begin
      run <= run_cfg;
      if (!run) begin
        presc <= '0;
        cnt   <= '0;
      end else if (tick) begin
        presc <= '0;
        cnt   <= cnt + 1'b1;
      end else begin
        presc <= presc + 1'b1;
      end
      if (load) ps_act <= ps_cfg;
    end
  end

  assert_idle_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> (cnt == '0 && presc == '0));

  assert_cnt_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(tick)) |-> (cnt == $past(cnt)));

  assert_ps_deferred_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(wrap)) |-> (ps_act == $past(ps_act)));
endmodule

// File: rtl/pwmx_chan.sv
module pwmx_chan
  import pwmx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty_cfg,
  output logic             out
);
  logic [CNT_W-1:0] duty_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) duty_act <= '0;
    else if (load) duty_act <= duty_cfg;
  end

  assign out = run && level_at(32'(cnt), 32'(duty_act));

  assert_full_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && duty_act == '1) |-> out);

  assert_zero_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && duty_act == '0 && cnt != '0) |-> !out);

  assert_duty_deferred_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(load)) |-> (duty_act == $past(duty_act)));
endmodule

// File: rtl/pwmx_top.sv
module pwmx_top
  import pwmx_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DUTY_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_en,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH*DUTY_W-1:0] duty_flat;
  logic [PS_W-1:0]          ps_cfg;
  logic                     run_cfg;
  logic                     run;
  logic [DUTY_W-1:0]        cnt;
  logic                     wrap;
  logic                     load;
  logic                     unused_wrap;

  assign unused_wrap = wrap;

  pwmx_regs #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .duty_flat(duty_flat),
    .ps_cfg(ps_cfg), .run_cfg(run_cfg), .ien_q(irq_en)
  );

  pwmx_timebase #(.CNT_W(DUTY_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run_cfg(run_cfg), .ps_cfg(ps_cfg),
    .run(run), .cnt(cnt), .wrap(wrap), .load(load)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwmx_chan #(.CNT_W(DUTY_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .run(run), .load(load), .cnt(cnt),
      .duty_cfg(duty_flat[g*DUTY_W +: DUTY_W]), .out(pwm_out[g])
    );
  end

  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pwm_out == '0));

  assert_common_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == '0) |-> (&pwm_out));
endmodule

// File: tb/tb_pwmx_top.sv
module tb_pwmx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_en;
  logic [3:0]  pwm_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // model state
  int po, pn, sw;
  int d_old [4];
  int d_new [4];

  pwmx_top dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_en(irq_en), .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] mk_ctrl(input int ps, input bit run);
    return (32'(ps % 16)) | (32'(ps / 16) << 11) | (32'(run) << 9);
  endfunction

  function automatic bit model(input int t, input int ch);
    int pp, tt, dd;
    if (t < sw) begin pp = po; tt = t; dd = d_old[ch]; end
    else begin pp = pn; tt = t - sw; dd = d_new[ch]; end
    return ((tt / (pp + 1)) % 256) <= dd;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    total++;
    if (bus_rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic chk_window(input int start, input int len, input string tag);
    bit seen = 1'b0;
    total++;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      for (int ch = 0; ch < 4; ch++) begin
        if (!seen && pwm_out[ch] !== model(start + i, ch)) begin
          seen = 1'b1;
          $display("FAIL %s t=%0d ch=%0d actual=%b expected=%b", tag, start + i, ch,
                   pwm_out[ch], model(start + i, ch));
        end
      end
    end
    if (seen) bad++;
  endtask

  task automatic chk_low(input int len, input string tag);
    bit seen = 1'b0;
    total++;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (!seen && pwm_out !== 4'b0) begin
        seen = 1'b1;
        $display("FAIL %s actual=%b expected=0000", tag, pwm_out);
      end
    end
    if (seen) bad++;
  endtask

  task automatic set_run(input int ps, input int d0, input int d1, input int d2, input int d3);
    d_old[0] = d0; d_old[1] = d1; d_old[2] = d2; d_old[3] = d3;
    for (int ch = 0; ch < 4; ch++) begin
      d_new[ch] = d_old[ch];
      wr(8'(4 * ch), 32'(d_old[ch]));
    end
    po = ps; pn = ps; sw = 1 << 30;
    wr(8'h50, mk_ctrl(ps, 1'b1));
  endtask

  task automatic stop();
    wr(8'h50, 32'h0);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    total++;
    if (pwm_out !== 4'b0 || irq_en !== 1'b0) begin
      bad++;
      $display("FAIL R9 outputs actual=%b/%b expected=0000/0", pwm_out, irq_en);
    end
    for (int ch = 0; ch < 4; ch++) chk_rd(8'(4 * ch), 32'h0, "R9 duty");
    chk_rd(8'h50, 32'h0, "R9 ctrl");
    chk_rd(8'h54, 32'h0, "R9 ien");

    // R1: duty readback, upper bits dropped
    for (int ch = 0; ch < 4; ch++) wr(8'(4 * ch), 32'hFFFF_FFA0 + 32'(ch));
    for (int ch = 0; ch < 4; ch++) chk_rd(8'(4 * ch), 32'hA0 + 32'(ch), "R1 duty");
    // R1: unmapped and misaligned writes ignored
    wr(8'h40, 32'hFF);
    wr(8'h58, 32'hFFFF_FFFF);
    wr(8'h01, 32'h33);
    chk_rd(8'h40, 32'h0, "R1 unmapped");
    chk_rd(8'h58, 32'h0, "R1 unmapped2");
    chk_rd(8'h01, 32'h0, "R1 misaligned read");
    chk_rd(8'h00, 32'hA0, "R1 misaligned write");
    chk_rd(8'h50, 32'h0, "R1 ctrl untouched");

    // R2: control fields, reserved bits dropped
    wr(8'h50, 32'hFFFF_FDFF);
    chk_rd(8'h50, 32'h0000_780F, "R2 ctrl fields");
    wr(8'h50, 32'h0);
    chk_rd(8'h50, 32'h0, "R2 ctrl clear");

    // R3: interrupt enable
    wr(8'h54, 32'hFFFF_FFFF);
    chk_rd(8'h54, 32'h1, "R3 ien set");
    total++;
    if (irq_en !== 1'b1) begin bad++; $display("FAIL R3 pin actual=%b expected=1", irq_en); end
    wr(8'h54, 32'hFFFF_FFFE);
    chk_rd(8'h54, 32'h0, "R3 ien clear");

    // R4 R5 R6: prescale 0, edge duties
    set_run(0, 0, 1, 128, 255);
    chk_window(0, 600, "R5 R6 ps0");
    stop();
    // R4: prescale 2, low nibble only
    set_run(2, 10, 0, 255, 200);
    chk_window(0, 1600, "R4 ps2");
    stop();
    // R4: prescale 0x11 uses the high nibble
    set_run(17, 3, 254, 0, 77);
    chk_window(0, 4700, "R4 ps17 high nibble");
    stop();

    // R8: mid-period changes deferred to the wrap
    set_run(1, 100, 5, 250, 60);
    chk_window(0, 50, "R8 before change");
    d_new[0] = 20; d_new[1] = 5; d_new[2] = 250; d_new[3] = 60;
    pn = 0; sw = 256 * 2;
    wr(8'h00, 32'd20);
    wr(8'h50, mk_ctrl(0, 1'b1));
    chk_window(54, 1200, "R8 deferred update");

    // R7: stop while high drives low, restart from count 0
    stop();
    chk_low(30, "R7 stopped low");
    set_run(0, 200, 200, 200, 200);
    chk_window(0, 5, "R7 start");
    wr(8'h50, 32'h0);
    @(negedge clk);
    chk_low(300, "R7 stop mid high");
    set_run(3, 0, 64, 128, 192);
    chk_window(0, 1100, "R7 restart");
    stop();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule